// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. Four incoming handshake lines (clear-to-send, data-set-ready, ring, carrier) are brought into the clock domain through a multi-stage synchroniser. Their current levels appear in the upper nibble of the status byte. The lower nibble records changes: one sticky change flag each for clear-to-send, data-set-ready and carrier, and a ring flag that is set only when the ring line is released. The control byte drives four outgoing handshake lines: request-to-send, terminal-ready and two general-purpose outputs.

In loopback mode the outgoing lines are held low. The status levels are then taken from the control bits rather than the pins, and changes in those looped levels set the change flags exactly as pin changes do. A read of the status byte returns its value and clears the change flags. The interrupt logic receives a request whenever a change flag is set and its modem-status enable input is high.

Top module: `modem_line_unit`

## Requirements
- R1: After reset, the control byte reads 0x08 (only general output 2 set) and the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send high, no change flags). `drv_out2` is 1, the other outgoing lines are 0, and `status_irq` is 0.
- R2: A write with `acc_sel`=0 stores `acc_wdata[4:0]` in the control byte. Reading the control byte returns those bits with bits 7..5 zero. Outside loopback the outgoing lines follow the control bits: terminal-ready=bit0, request-to-send=bit1, general output 1=bit2, general output 2=bit3. Bit4 selects loopback.
- R3: Outside loopback, the status upper nibble follows the synchronised pins: carrier=bit7, ring=bit6, data-set-ready=bit5, clear-to-send=bit4.
- R4: Status bit0 (clear-to-send), bit1 (data-set-ready) and bit3 (carrier) are set when the level changes in either direction. Each stays set until a status read, through any number of further changes.
- R5: Status bit2 is set only when the ring level falls from 1 to 0, never when it rises.
- R6: A status read (`acc_sel`=1) returns the byte as it stood before the read and clears all four change flags. A change detected in the same cycle as the read is kept for the next read.
- R7: In loopback the status levels read carrier=general output 2, ring=general output 1, data-set-ready=terminal-ready and clear-to-send=request-to-send. The pins have no effect on the status, and all four outgoing lines are held at 0.
- R8: Level changes caused by entering or leaving loopback, or by control writes while in loopback, set the change flags under the rules of R4 and R5.
- R9: `status_irq` is 1 exactly when `msr_irq_en` is 1 and at least one change flag is set.
- R10: A write with `acc_sel`=1 has no effect on the control byte, the status byte or the outgoing lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_sel | input | 1 | 0 selects the control byte, 1 selects the status byte |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered on the clock after the read strobe |
| msr_irq_en | input | 1 | Modem-status interrupt enable |
| line_cts | input | 1 | Clear-to-send pin, active high, asynchronous |
| line_dsr | input | 1 | Data-set-ready pin, active high, asynchronous |
| line_ri | input | 1 | Ring pin, active high, asynchronous |
| line_dcd | input | 1 | Carrier pin, active high, asynchronous |
| drv_rts | output | 1 | Request-to-send output |
| drv_dtr | output | 1 | Terminal-ready output |
| drv_out1 | output | 1 | General output 1 |
| drv_out2 | output | 1 | General output 2 |
| status_irq | output | 1 | Modem-status interrupt request |

## Verification
Several properties are checked by assertions on every cycle. Change flags are sticky until a read, and a detected change always lands in its flag. A ring rise never sets the ring flag, and a read with no concurrent change leaves the flags empty. Loopback keeps the outgoing lines low, a status-address write leaves the control byte alone, and the request drops only through a read while the enable stays high. Other behaviour can only be shown by the bench scenarios: the exact bit mapping of loopback, the reset values, the value returned by a read that collides with a new change, and the agreement of the whole byte with an independent model over random sequences of pin, mode and control changes.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int NIB    = 4;
  localparam int CTRL_W = 5;
  localparam int BYTE_W = 8;

  // control field positions (decoded by the loop mapping)
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  localparam mline_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1 << C_OUT2);

  // looped status levels derived from the control byte
  function automatic mline_t loop_map(input logic [CTRL_W-1:0] c);
    mline_t m;
    m.dcd = c[C_OUT2];
    m.ri  = c[C_OUT1];
    m.dsr = c[C_DTR];
    m.cts = c[C_RTS];
    return m;
  endfunction

  // change events: any edge on dcd/dsr/cts, falling edge only on ri
  function automatic logic [NIB-1:0] line_events(input mline_t old_l, input mline_t new_l);
    logic [NIB-1:0] e;
    e[3] = old_l.dcd ^ new_l.dcd;
    e[2] = old_l.ri & ~new_l.ri;
    e[1] = old_l.dsr ^ new_l.dsr;
    e[0] = old_l.cts ^ new_l.cts;
    return e;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg import modem_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_status,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              loop_on,
  output logic              o_dtr,
  output logic              o_rts,
  output logic              o_out1,
  output logic              o_out2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= wdata;
  end

  assign loop_on = ctrl_q[C_LOOP];
  assign o_dtr  = ctrl_q[C_DTR]  & ~loop_on;
  assign o_rts  = ctrl_q[C_RTS]  & ~loop_on;
  assign o_out1 = ctrl_q[C_OUT1] & ~loop_on;
  assign o_out2 = ctrl_q[C_OUT2] & ~loop_on;

  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !wr_ctrl) |=> $stable(ctrl_q)); // R10

  AST_LOOP_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_LOOP] |-> !(o_dtr || o_rts || o_out1 || o_out2)); // R7
endmodule

// File: rtl/modem_delta.sv
module modem_delta import modem_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  mline_t         lvl,
  input  logic           clr,
  output logic [NIB-1:0] delta_q,
  output logic [NIB-1:0] evt
);
  mline_t prev_q;

  assign evt = line_events(prev_q, lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= LINE_RST;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl;
      delta_q <= (clr ? '0 : delta_q) | evt;
    end
  end

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R4

  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((delta_q & $past(evt)) == $past(evt))); // R6

  AST_RI_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !delta_q[2] && !prev_q.ri && lvl.ri) |=> !delta_q[2]); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (delta_q == '0)); // R6
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit import modem_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic       acc_sel,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       msr_irq_en,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_ri,
  input  logic       line_dcd,
  output logic       drv_rts,
  output logic       drv_dtr,
  output logic       drv_out1,
  output logic       drv_out2,
  output logic       status_irq
);
  logic              wr_ctrl, wr_status, rd_ctrl, rd_status;
  logic [CTRL_W-1:0] ctrl_q;
  logic              loop_on;
  logic [NIB-1:0]    pins_sync;
  mline_t            pin_lvl, cur_lvl;
  logic [NIB-1:0]    delta_q, delta_evt;
  logic [BYTE_W-1:0] status_byte;
  logic [2:0]        unused_wdata_hi;

  assign wr_ctrl   = acc_wr & ~acc_sel;
  assign wr_status = acc_wr &  acc_sel;
  assign rd_ctrl   = acc_rd & ~acc_sel;
  assign rd_status = acc_rd &  acc_sel;
  assign unused_wdata_hi = acc_wdata[7:5];

  modem_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_status(wr_status),
    .wdata(acc_wdata[CTRL_W-1:0]), .ctrl_q(ctrl_q), .loop_on(loop_on),
    .o_dtr(drv_dtr), .o_rts(drv_rts), .o_out1(drv_out1), .o_out2(drv_out2)
  );

  modem_sync #(.WIDTH(NIB), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({line_dcd, line_ri, line_dsr, line_cts}),
    .sync_out(pins_sync)
  );

  assign pin_lvl = mline_t'(pins_sync);
  assign cur_lvl = loop_on ? loop_map(ctrl_q) : pin_lvl;

  modem_delta u_delta (
    .clk(clk), .rst_n(rst_n), .lvl(cur_lvl), .clr(rd_status),
    .delta_q(delta_q), .evt(delta_evt)
  );

  assign status_byte = {cur_lvl, delta_q};
  assign status_irq  = msr_irq_en & (|delta_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_rdata <= '0;
    else if (rd_status) acc_rdata <= status_byte;
    else if (rd_ctrl) acc_rdata <= {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
  end

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> (acc_rdata[7:5] == 3'b000)); // R2

  AST_IRQ_DROP_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status_irq) && msr_irq_en && $past(msr_irq_en)) |-> $past(rd_status)); // R9
endmodule

// File: tb/modem_line_unit_test.sv
module modem_line_unit_test;
  logic clk = 0, rst_n = 0;
  logic acc_wr = 0, acc_rd = 0, acc_sel = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] acc_rdata;
  logic msr_irq_en = 0;
  logic line_cts = 1, line_dsr = 1, line_ri = 0, line_dcd = 1;
  logic drv_rts, drv_dtr, drv_out1, drv_out2, status_irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [4:0] m_ctrl;
  logic [3:0] m_lvl, m_delta, m_pins;

  always #2 clk = ~clk;

  modem_line_unit uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] eff_lvl(input logic [4:0] c, input logic [3:0] p);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return p;
  endfunction

  function automatic logic [3:0] chg(input logic [3:0] o, input logic [3:0] n);
    return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
  endfunction

  task automatic model_update();
    logic [3:0] nl;
    nl = eff_lvl(m_ctrl, m_pins);
    m_delta = m_delta | chg(m_lvl, nl);
    m_lvl = nl;
  endtask

  task automatic set_pins(input logic [3:0] p);
    {line_dcd, line_ri, line_dsr, line_cts} = p;
    m_pins = p;
    tick(4);
    model_update();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    acc_wr = 1; acc_sel = sel; acc_wdata = d;
    tick(1);
    acc_wr = 0;
    tick(3);
    if (!sel) begin m_ctrl = d[4:0]; model_update(); end
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    acc_rd = 1; acc_sel = sel;
    tick(1);
    acc_rd = 0;
    d = acc_rdata;
  endtask

  task automatic check_outs(input string req);
    logic [3:0] e;
    e = m_ctrl[4] ? 4'b0 : m_ctrl[3:0];
    check(req, {drv_out2, drv_out1, drv_rts, drv_dtr}, e);
    check("R9", status_irq, msr_irq_en & (|m_delta));
  endtask

  task automatic check_status(input string req);
    logic [7:0] d;
    rd(1, d);
    check(req, d, {m_lvl, m_delta});
    m_delta = 0;
  endtask

  initial begin
    logic [7:0] d;
    m_ctrl = 5'h08; m_lvl = 4'hB; m_delta = 0; m_pins = 4'hB;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst_n = 1;
    tick(2);

    // R1 reset state
    check("R1 outs", {drv_out2, drv_out1, drv_rts, drv_dtr}, 4'b1000);
    check("R1 irq", status_irq, 0);
    rd(0, d); check("R1 ctrl", d, 8'h08);
    rd(1, d); check("R1 status", d, 8'hB0);

    // R2 control write, upper bits dropped
    wr(0, 8'hE5); rd(0, d); check("R2 readback", d, 8'h05);
    check_outs("R2 outs");
    wr(0, 8'h0A); check_outs("R2 outs b");

    // R3/R4 carrier toggle twice: flag stays set
    msr_irq_en = 1;
    set_pins(4'h3);
    check("R9 irq on", status_irq, 1);
    set_pins(4'hB);
    check_status("R4 sticky dcd");
    check("R9 irq off", status_irq, 0);

    // R5 ring rise: no flag; ring fall: flag
    set_pins(4'hF); check_status("R5 ri rise");
    set_pins(4'hB); check_status("R5 ri fall");

    // R6 change colliding with a read
    line_cts = 0; m_pins = 4'hA;
    tick(2);
    acc_rd = 1; acc_sel = 1; tick(1); acc_rd = 0;
    check("R6 collide value", acc_rdata, {4'hA, 4'h0});
    m_lvl = 4'hA; m_delta = 4'h1;
    tick(2);
    check_status("R6 kept");

    // R7 loopback mapping, one control bit at a time
    set_pins(4'hF);
    check_status("R3 pins");
    for (int b = 0; b < 4; b++) begin
      wr(0, 8'h10 | (8'h1 << b));
      check_outs("R7 outs low");
      check_status("R8 loop status");
    end
    set_pins(4'h0);
    check_status("R7 pins ignored");
    wr(0, 8'h00);
    check_status("R8 leave loop");

    // R10 status write ignored
    wr(0, 8'h06);
    check_status("R10 pre");
    wr(1, 8'hFF);
    rd(0, d); check("R10 ctrl", d, 8'h06);
    check_outs("R10 outs");
    check_status("R10 status");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      msr_irq_en = 1'($urandom % 2);
      case ($urandom % 6)
        0, 1: set_pins(4'($urandom));
        2: wr(0, 8'($urandom));
        3: check_status("R4 random status");
        4: begin rd(0, d); check("R2 random ctrl", d, {3'b0, m_ctrl}); end
        default: begin wr(1, 8'($urandom)); tick(1); end
      endcase
      tick(1);
      check_outs("R7 random outs");
    end
    check_status("R6 final");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule